// File: doc/BRIEF.md
# Ones-Complement Adder/Subtractor with End-Around Carry

This block adds or subtracts two signed integers held in ones-complement form. A negative value is the bitwise inverse of its magnitude, so that inverse is equal to (2^n - 1) minus the magnitude. Subtraction therefore needs no separate datapath: the subtrahend is inverted and then added.

The two n-bit patterns are first summed in a ripple chain that starts at the least significant bit. The carry that leaves the sign position is not thrown away. It is fed into the least significant bit of a second increment pass, which has the same effect as subtracting 2^n and adding 1. The increment pass is applied once only. Zero has two encodings: all zeros (positive zero) and all ones (negative zero). A flag reports a negative-zero result. An optional parameter rewrites negative zero as positive zero.

An overflow flag reports a sum that does not fit in n bits. The result can be taken straight from the logic or through one output register.

Top module: `oc_eac_adder`

## Requirements
- R1: With `sub_i`=0 the output pattern is u = A + B, with both taken as unsigned patterns. If u reaches 2^WIDTH, the output is u - (2^WIDTH - 1) instead (end-around carry).
- R2: With `sub_i`=1, the effective second operand is the bitwise inverse of `b_i`, and R1 applies to A + ~B.
- R3: The value of a pattern x is x when its MSB is 0, and -(~x) when its MSB is 1. When the true sum of the effective operand values lies within ±(2^(WIDTH-1) - 1), the output represents exactly that sum.
- R4: `ovf_o` is 1 exactly when the effective operands share an MSB and the output's MSB differs from it. This is the same as the true sum falling outside ±(2^(WIDTH-1) - 1).
- R5: A true sum of zero gives the all-ones pattern. The one exception is when both effective operands are all zeros, which gives all zeros.
- R6: `neg_zero_o` is 1 exactly when the end-around sum, before any normalisation, is all ones.
- R7: With `NORM_ZERO`=1, an all-ones sum is output as all zeros and every other pattern is unchanged. With `NORM_ZERO`=0, the all-ones sum is output as it is.
- R8: With `REG_OUT`=1, the outputs follow the inputs of the previous rising clock edge. While `rst_ni` is low, all outputs are 0.
- R9: The end-around increment never produces a further carry out of the sign position. The carry is applied once only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| a_i | input | WIDTH | First operand, ones-complement |
| b_i | input | WIDTH | Second operand, ones-complement |
| sub_i | input | 1 | 1 selects A - B, 0 selects A + B |
| sum_o | output | WIDTH | Ones-complement result |
| ovf_o | output | 1 | Signed overflow |
| neg_zero_o | output | 1 | End-around sum was all ones |

## Verification
A four-bit configuration is swept over every A, B and operation pair. There are two instances, one that keeps negative zero and one that normalises it, so any difference between their outputs can only come from R7.

Pairs whose unsigned sum stays below 2^n never take the end-around path. Pairs that cross 2^n do take it, so an adder that drops the carry or loops it twice shows up at once.

Mixed-sign pairs such as x + (-x) must give all ones, while +0 + +0 must give all zeros, so an adder that confuses the two zeros is exposed. Same-sign pairs at the edge of the range tell a true overflow apart from a sum that only just fits.

// File: rtl/oc_eac_pkg.sv
package oc_eac_pkg;
  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } oc_op_e;
endpackage

// File: rtl/oc_operand_cond.sv
module oc_operand_cond
  import oc_eac_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] b_eff_o
);
  oc_op_e op;
  assign op = oc_op_e'(sub_i);

  always_comb begin
    unique case (op)
      OP_SUB:  b_eff_o = ~b_i;
      default: b_eff_o = b_i;
    endcase
  end
endmodule

// File: rtl/oc_ripple_add.sv
module oc_ripple_add #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  logic [WIDTH:0] c;
  assign c[0] = cin_i;

  for (genvar g = 0; g < WIDTH; g++) begin : g_fa
    assign sum_o[g] = a_i[g] ^ b_i[g] ^ c[g];
    assign c[g+1]   = (a_i[g] & b_i[g]) | (c[g] & (a_i[g] ^ b_i[g]));
  end

  assign cout_o = c[WIDTH];
endmodule

// File: rtl/oc_eac_stage.sv
module oc_eac_stage #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             ovf_o,
  output logic             wrap_cout_o
);
  localparam int unsigned MSB = WIDTH - 1;

  logic [WIDTH-1:0] raw_sum;
  logic             raw_cout;

  // first pass: plain add, no carry in
  oc_ripple_add #(.WIDTH(WIDTH)) i_pass0 (
    .a_i   (a_i),
    .b_i   (b_i),
    .cin_i (1'b0),
    .sum_o (raw_sum),
    .cout_o(raw_cout)
  );

  // second pass: carry out of the sign bit re-enters at the LSB, once
  oc_ripple_add #(.WIDTH(WIDTH)) i_pass1 (
    .a_i   (raw_sum),
    .b_i   ({WIDTH{1'b0}}),
    .cin_i (raw_cout),
    .sum_o (sum_o),
    .cout_o(wrap_cout_o)
  );

  assign ovf_o = (a_i[MSB] == b_i[MSB]) && (sum_o[MSB] != a_i[MSB]);
endmodule

// File: rtl/oc_eac_adder.sv
module oc_eac_adder
  import oc_eac_pkg::*;
#(
  parameter int unsigned WIDTH     = 8,
  parameter bit          NORM_ZERO = 1'b0,
  parameter bit          REG_OUT   = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             ovf_o,
  output logic             neg_zero_o
);
  localparam logic [WIDTH-1:0] ONES = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ZERO = {WIDTH{1'b0}};

  logic [WIDTH-1:0] b_eff;
  logic [WIDTH-1:0] eac_sum;
  logic             eac_ovf;
  logic             eac_wrap;
  logic             nz;
  logic [WIDTH-1:0] res;

  oc_operand_cond #(.WIDTH(WIDTH)) i_cond (
    .b_i    (b_i),
    .sub_i  (sub_i),
    .b_eff_o(b_eff)
  );

  oc_eac_stage #(.WIDTH(WIDTH)) i_stage (
    .a_i        (a_i),
    .b_i        (b_eff),
    .sum_o      (eac_sum),
    .ovf_o      (eac_ovf),
    .wrap_cout_o(eac_wrap)
  );

  assign nz = (eac_sum == ONES);

  if (NORM_ZERO) begin : g_norm
    assign res = nz ? ZERO : eac_sum;
  end else begin : g_keep
    assign res = eac_sum;
  end

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sum_o      <= ZERO;
        ovf_o      <= 1'b0;
        neg_zero_o <= 1'b0;
      end else begin
        sum_o      <= res;
        ovf_o      <= eac_ovf;
        neg_zero_o <= nz;
      end
    end

    // R4
    mixed_sign_no_ovf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (a_i[WIDTH-1] != (b_i[WIDTH-1] ^ sub_i)) |=> !ovf_o);
    // R5
    pos_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (a_i == ZERO && (b_i ^ {WIDTH{sub_i}}) == ZERO) |=> (sum_o == ZERO && !neg_zero_o));
    // R1
    add_plus_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!sub_i && b_i == ZERO && a_i != ONES) |=> (sum_o == $past(a_i)));
    // R7
    nz_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      neg_zero_o |-> (sum_o == (NORM_ZERO ? ZERO : ONES)));
  end else begin : g_comb
    assign sum_o      = res;
    assign ovf_o      = eac_ovf;
    assign neg_zero_o = nz;

    // R4
    mixed_sign_no_ovf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (a_i[WIDTH-1] != (b_i[WIDTH-1] ^ sub_i)) |-> !ovf_o);
    // R5
    pos_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (a_i == ZERO && (b_i ^ {WIDTH{sub_i}}) == ZERO) |-> (sum_o == ZERO && !neg_zero_o));
    // R1
    add_plus_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!sub_i && b_i == ZERO && a_i != ONES) |-> (sum_o == a_i));
    // R7
    nz_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      neg_zero_o |-> (sum_o == (NORM_ZERO ? ZERO : ONES)));
  end

  // R9
  single_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eac_wrap);
endmodule

// File: tb/test_oc_eac_adder.sv
`timescale 1ns/1ps
module test_oc_eac_adder;
  localparam int W = 4;
  localparam int M = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] a = '0;
  logic [W-1:0] b = '0;
  logic         sub = 1'b0;
  logic [W-1:0] sum_k, sum_n;
  logic         ovf_k, ovf_n, nz_k, nz_n;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  oc_eac_adder #(.WIDTH(W), .NORM_ZERO(1'b0), .REG_OUT(1'b1)) i_oc_eac_adder (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a), .b_i(b), .sub_i(sub),
    .sum_o(sum_k), .ovf_o(ovf_k), .neg_zero_o(nz_k)
  );

  oc_eac_adder #(.WIDTH(W), .NORM_ZERO(1'b1), .REG_OUT(1'b1)) i_oc_eac_adder_nz (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a), .b_i(b), .sub_i(sub),
    .sum_o(sum_n), .ovf_o(ovf_n), .neg_zero_o(nz_n)
  );

  function automatic int val(input int x);
    if (x[W-1]) return -((~x) & M);
    return x;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s a=%0d b=%0d sub=%0d actual=%0d expected=%0d", req, a, b, sub, act, exp);
    end
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(sum_k == '0, "R8 reset sum", int'(sum_k), 0);
    chk(ovf_k == 1'b0 && nz_k == 1'b0, "R8 reset flags", int'({ovf_k, nz_k}), 0);
    chk(sum_n == '0 && ovf_n == 1'b0 && nz_n == 1'b0, "R8 reset nz-inst", int'(sum_n), 0);
    rst_n = 1'b1;

    for (int s = 0; s < 2; s++) begin
      for (int ai = 0; ai <= M; ai++) begin
        for (int bi = 0; bi <= M; bi++) begin
          int ub, u, epat, ti, epat_n;
          bit eovf;
          @(negedge clk);
          a = W'(ai);
          b = W'(bi);
          sub = s[0];
          ub = s ? ((~bi) & M) : bi;
          u = ai + ub;
          epat = (u > M) ? u - M : u;
          ti = val(ai) + val(ub);
          eovf = (ti > (M >> 1)) || (ti < -(M >> 1));
          epat_n = (epat == M) ? 0 : epat;
          @(negedge clk);
          // R1 / R2 end-around pattern
          chk(int'(sum_k) == epat, s ? "R2 sub pattern" : "R1 add pattern", int'(sum_k), epat);
          // R4
          chk(ovf_k == eovf, "R4 overflow", int'(ovf_k), int'(eovf));
          // R6
          chk(nz_k == (epat == M), "R6 neg_zero", int'(nz_k), int'(epat == M));
          // R7
          chk(int'(sum_n) == epat_n, "R7 normalised", int'(sum_n), epat_n);
          chk(nz_n == (epat == M) && ovf_n == eovf, "R7 flags", int'({ovf_n, nz_n}),
              int'({eovf, epat == M}));
          if (!eovf) begin
            // R3
            chk(val(int'(sum_k)) == ti, "R3 value", val(int'(sum_k)), ti);
            if (ti == 0) begin
              // R5
              chk(int'(sum_k) == ((ai == 0 && ub == 0) ? 0 : M), "R5 zero encoding",
                  int'(sum_k), (ai == 0 && ub == 0) ? 0 : M);
            end
          end
        end
      end
    end

    // R9 largest wrap: all-ones + all-ones stays all-ones, one pass only
    @(negedge clk);
    a = '1; b = '1; sub = 1'b0;
    @(negedge clk);
    chk(sum_k == '1 && !ovf_k, "R9 single wrap", int'(sum_k), M);
    // R8 latency: output holds until next edge samples new inputs
    a = 4'd1; b = 4'd2;
    #1;
    chk(sum_k == '1, "R8 latency", int'(sum_k), M);
    @(negedge clk);
    chk(sum_k == 4'd3, "R8 latency update", int'(sum_k), 3);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule